// File: doc/BRIEF.md
# Miss-Frequency Estimator with Counting Filters

This block keeps a running estimate of how many times each block address has shown up in a last-level cache miss stream. Storage is split into several banks of small saturating counters. Each bank is addressed by a different bit slice of the block address. Every miss presented on the update port bumps the addressed counter in all banks. Two addresses that collide in one bank seldom also collide in every other bank. For that reason the smallest of the addressed counters is a tight upper bound on the true count.

When a block leaves the cache, its address goes to the query port. One cycle later the block returns the minimum of the counters that address selects. A replacement policy can use that figure to rank evicted blocks by how often they have missed. A synchronous clear sweeps every counter back to zero over a fixed number of cycles, and it blocks updates while the sweep runs.

Top module: `miss_freq_est`

## Requirements
- R1: After reset every counter is zero, `q_valid_o` is low and `clr_busy_o` is low.
- R2: `q_valid_o` is high in exactly the cycles that follow a cycle with `q_valid_i` high.
- R3: When `q_valid_o` is high, `q_freq_o` equals the minimum over all banks of the counter that bank b selects with address bits `SLICE_HI[b]` down to `SLICE_LO[b]` of the query address.
- R4: An accepted update (`u_valid_i` high while `clear_i` and `clr_busy_o` are both low) raises by one, in every bank, the counter that the update address selects. This applies only to counters below their maximum.
- R5: A counter at its maximum value of 2^CNT_W-1 stays there on further updates and does not wrap.
- R6: If an update and a query arrive in the same cycle, the query reports the counter values as they were before that update.
- R7: A `clear_i` pulse while idle raises `clr_busy_o` on the next cycle. `clr_busy_o` then stays high for exactly 2^W cycles, where W is the widest slice width. After that every counter reads zero.
- R8: An update offered in the cycle `clear_i` is high, or in any cycle `clr_busy_o` is high, changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| u_valid_i | input | 1 | Miss address present |
| u_addr_i | input | ADDR_W | Missing block address |
| q_valid_i | input | 1 | Query address present |
| q_addr_i | input | ADDR_W | Evicted block address |
| clear_i | input | 1 | Start a counter-clearing sweep |
| q_valid_o | output | 1 | Estimate valid |
| q_freq_o | output | CNT_W | Minimum of the addressed counters |
| clr_busy_o | output | 1 | Clearing sweep in progress |

## Verification
The bench builds the block with a 10-bit address, 3-bit counters and five slices of 3 to 5 bits. The narrow slices force frequent collisions in each bank, so the minimum-combine is exercised against real aliasing. The short counters reach saturation after only seven hits to one address. The widest slice is 5 bits, so a full clear takes 32 cycles. That window is short enough to count exactly and to fill with blocked update attempts.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  function automatic int slice_width(input int hi, input int lo);
    return hi - lo + 1;
  endfunction
endpackage

// File: rtl/mfe_clear_ctrl.sv
module mfe_clear_ctrl #(
  parameter int SWEEP_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  output logic               busy_o,
  output logic [SWEEP_W-1:0] sweep_idx_o
);
  localparam logic [SWEEP_W-1:0] LastIdx = {SWEEP_W{1'b1}};

  logic               busy_q;
  logic [SWEEP_W-1:0] sweep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sweep_q <= '0;
    end else if (busy_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (sweep_q == LastIdx) busy_q <= 1'b0;
    end else if (clear_i) begin
      busy_q  <= 1'b1;
      sweep_q <= '0;
    end
  end

  assign busy_o      = busy_q;
  assign sweep_idx_o = sweep_q;

  a_r7_sweep_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && sweep_q == LastIdx) |=> !busy_q);
  a_r7_sweep_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && clear_i) |=> (busy_q && sweep_q == '0));
endmodule

// File: rtl/mfe_bank.sv
module mfe_bank #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] rd_q;
  logic [CNT_W-1:0] upd_cur;

  assign upd_cur = cnt_q[upd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
      rd_q <= '0;
    end else begin
      rd_q <= cnt_q[rd_idx_i];  // old value: same-cycle update not visible
      if (clr_en_i) cnt_q[clr_idx_i] <= '0;
      else if (upd_en_i && upd_cur != CntMax) cnt_q[upd_idx_i] <= upd_cur + 1'b1;
    end
  end

  assign rd_cnt_o = rd_q;

  a_r4_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !clr_en_i && upd_cur != CntMax) |=>
      cnt_q[$past(upd_idx_i)] == $past(upd_cur) + 1'b1);
  a_r5_hold_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_cur == CntMax) |=> cnt_q[$past(upd_idx_i)] == CntMax);
  a_r7_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> cnt_q[$past(clr_idx_i)] == '0);
endmodule

// File: rtl/mfe_min_reduce.sv
module mfe_min_reduce #(
  parameter int N     = 5,
  parameter int CNT_W = 4
) (
  input  logic [N-1:0][CNT_W-1:0] val_i,
  output logic [CNT_W-1:0]        min_o
);
  logic [N-1:0][CNT_W-1:0] chain;

  assign chain[0] = val_i[0];
  for (genvar g = 1; g < N; g++) begin : g_chain
    assign chain[g] = (val_i[g] < chain[g-1]) ? val_i[g] : chain[g-1];
  end
  assign min_o = chain[N-1];
endmodule

// File: rtl/miss_freq_est.sv
module miss_freq_est
  import mfe_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int CNT_W     = 4,
  parameter int NUM_BANKS = 5,
  parameter int SLICE_HI [NUM_BANKS] = '{24, 18, 25, 22, 9},
  parameter int SLICE_LO [NUM_BANKS] = '{19, 11, 23, 15, 0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              u_valid_i,
  input  logic [ADDR_W-1:0] u_addr_i,
  input  logic              q_valid_i,
  input  logic [ADDR_W-1:0] q_addr_i,
  input  logic              clear_i,
  output logic              q_valid_o,
  output logic [CNT_W-1:0]  q_freq_o,
  output logic              clr_busy_o
);
  function automatic int widest();
    int m = 1;
    for (int i = 0; i < NUM_BANKS; i++)
      if (slice_width(SLICE_HI[i], SLICE_LO[i]) > m) m = slice_width(SLICE_HI[i], SLICE_LO[i]);
    return m;
  endfunction
  localparam int SWEEP_W = widest();

  logic                          busy;
  logic [SWEEP_W-1:0]            sweep_idx;
  logic                          upd_ok;
  logic [NUM_BANKS-1:0][CNT_W-1:0] bank_cnt;
  logic                          q_valid_q;

  mfe_clear_ctrl #(.SWEEP_W(SWEEP_W)) u_clr (
    .clk_i, .rst_ni, .clear_i,
    .busy_o(busy), .sweep_idx_o(sweep_idx)
  );

  assign upd_ok = u_valid_i && !busy && !clear_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W = slice_width(SLICE_HI[b], SLICE_LO[b]);
    mfe_bank #(.IDX_W(W), .CNT_W(CNT_W)) u_bank (
      .clk_i, .rst_ni,
      .upd_en_i (upd_ok),
      .upd_idx_i(u_addr_i[SLICE_HI[b]:SLICE_LO[b]]),
      .clr_en_i (busy),
      .clr_idx_i(sweep_idx[W-1:0]),
      .rd_idx_i (q_addr_i[SLICE_HI[b]:SLICE_LO[b]]),
      .rd_cnt_o (bank_cnt[b])
    );
  end

  mfe_min_reduce #(.N(NUM_BANKS), .CNT_W(CNT_W)) u_min (
    .val_i(bank_cnt), .min_o(q_freq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_valid_q <= 1'b0;
    else         q_valid_q <= q_valid_i;
  end
  assign q_valid_o  = q_valid_q;
  assign clr_busy_o = busy;

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_i |=> q_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_valid_i |=> !q_valid_o);
  a_r3_min_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> (q_freq_o <= bank_cnt[0] && q_freq_o <= bank_cnt[NUM_BANKS-1]));
endmodule

// File: tb/sim_miss_freq_est.sv
module sim_miss_freq_est;
  localparam int AW = 10;
  localparam int CW = 3;
  localparam int NB = 5;
  localparam int HI [NB] = '{9, 6, 8, 4, 2};
  localparam int LO [NB] = '{7, 3, 5, 0, 0};
  localparam int MAXV = 7;
  localparam int SWEEP = 32;

  logic clk = 0, rst_n = 0;
  logic u_valid = 0, q_valid = 0, clear = 0;
  logic [AW-1:0] u_addr = '0, q_addr = '0;
  logic q_valid_o, clr_busy_o;
  logic [CW-1:0] q_freq_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int mdl [NB][32];

  always #2 clk = ~clk;

  miss_freq_est #(.ADDR_W(AW), .CNT_W(CW), .NUM_BANKS(NB),
                  .SLICE_HI(HI), .SLICE_LO(LO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .u_valid_i(u_valid), .u_addr_i(u_addr),
    .q_valid_i(q_valid), .q_addr_i(q_addr), .clear_i(clear),
    .q_valid_o(q_valid_o), .q_freq_o(q_freq_o), .clr_busy_o(clr_busy_o));

  function automatic int idx(int b, logic [AW-1:0] a);
    return int'((a >> LO[b]) & ((1 << (HI[b] - LO[b] + 1)) - 1));
  endfunction

  function automatic int est(logic [AW-1:0] a);
    int m = MAXV;
    for (int b = 0; b < NB; b++) if (mdl[b][idx(b, a)] < m) m = mdl[b][idx(b, a)];
    return m;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit uv, logic [AW-1:0] ua, bit qv, logic [AW-1:0] qa, string req);
    int e;
    u_valid = uv; u_addr = ua; q_valid = qv; q_addr = qa;
    e = est(qa);
    @(negedge clk);
    chk("R2", q_valid_o, qv);
    if (qv) chk(req, q_freq_o, e);
    if (uv) for (int b = 0; b < NB; b++)
      if (mdl[b][idx(b, ua)] < MAXV) mdl[b][idx(b, ua)]++;
    u_valid = 0; q_valid = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int busy_cnt;
    void'($urandom(1234));
    for (int b = 0; b < NB; b++) for (int i = 0; i < 32; i++) mdl[b][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", clr_busy_o, 0);
    chk("R1 valid", q_valid_o, 0);
    cyc(0, 0, 1, 10'h2A5, "R1 zero");
    cyc(0, 0, 0, 0, "R2");
    // R4: single address counted
    cyc(1, 10'h155, 0, 0, "R4");
    cyc(0, 0, 1, 10'h155, "R4 one");
    // R5: saturation
    for (int i = 0; i < 10; i++) cyc(1, 10'h0F3, 0, 0, "R5");
    cyc(0, 0, 1, 10'h0F3, "R5 sat");
    chk("R5 value", q_freq_o, MAXV);
    // R6: same-cycle update and query
    cyc(1, 10'h301, 0, 0, "R6");
    cyc(1, 10'h301, 1, 10'h301, "R6 pre-incr");
    cyc(0, 0, 1, 10'h301, "R6 after");
    // R3: random mix against model
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] ua = AW'($urandom);
      logic [AW-1:0] qa = AW'($urandom);
      cyc(($urandom % 3) != 0, ua, ($urandom % 2) == 1, qa, "R3");
    end
    // R7/R8: clear sweep with blocked updates
    clear = 1; u_valid = 1; u_addr = 10'h0F3;
    @(negedge clk);
    clear = 0;
    busy_cnt = 0;
    while (clr_busy_o && busy_cnt < 100) begin
      busy_cnt++;
      u_addr = AW'($urandom);
      @(negedge clk);
    end
    u_valid = 0;
    chk("R7 busy cycles", busy_cnt, SWEEP);
    for (int b = 0; b < NB; b++) for (int i = 0; i < 32; i++) mdl[b][i] = 0;
    cyc(0, 0, 1, 10'h0F3, "R8 ignored");
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, AW'($urandom), "R7 zero");
    // after clear, counting resumes
    for (int i = 0; i < 100; i++)
      cyc(1, AW'($urandom % 64), 1, AW'($urandom % 64), "R3 post");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule